// File: doc/BRIEF.md
# Iterative 1280-bit Sponge Permutation Core

This block applies a keyless permutation to a 1280-bit state and computes one full round in every clock cycle. The state is a grid of twenty 64-bit words, four rows by five columns. A single start pulse captures the input state and chooses between a short run of 6 rounds, used for each data block, and a long run of 12 rounds, used to set up a session. When the last round has been computed, the block pulses a completion flag. The result stays on the output until the next run is started.

Each round applies five steps in a fixed order. First, every 4-element column slice is multiplied by a fixed 4x4 matrix over GF(2^5). Next, each word is rotated by its own fixed amount. The words are then moved to new grid positions. A 5-bit nonlinear substitution follows. Finally, a 64-bit round constant is added into one word. The block does not generate the round constants. It publishes the index of the current round, and a separate generator returns the matching constant in the same cycle.

Top module: `sponge_round_core`

## Requirements
- R1: After reset, busy_o and done_o are 0, rnd_idx_o is 0 and state_o is all zeros.
- R2: A start_i sampled while busy_o is 0 captures state_i and begins a run. The run is 12 rounds when mode_long_i is 1 and 6 rounds when it is 0. done_o rises exactly that many cycles after the capturing edge.
- R3: done_o is high for exactly one cycle, and busy_o is already 0 in that cycle.
- R4: start_i, state_i and mode_long_i are ignored while busy_o is 1. The result and its timing are the same as for an undisturbed run.
- R5: While busy, rnd_idx_o counts 0, 1, 2 and so on, one step per cycle. The rc_i value presented in a cycle is the constant used by the round computed at the end of that cycle.
- R6: Word (x,y), with row x in 0..3 and column y in 0..4, occupies bits 64*(x+4*y) to 64*(x+4*y)+63 of state_i and state_o. Bit z of that word is bit z of this slice.
- R7: Column mix: for each bit z, a 5-bit element is formed for each row x, with bit y taken from word (x,y). These four elements are multiplied by the rows [2,1,1,1], [1,1,18,2], [1,2,1,18] and [1,18,2,1] in GF(2^5), reduced by x^5+x^2+1.
- R8: Rotation: each word is rotated left by a fixed amount. Row 0 uses 0, 36, 3, 41 and 18. Row 1 uses 1, 44, 10, 45 and 2. Row 2 uses 62, 6, 43, 15 and 61. Row 3 uses 28, 55, 25 and 21, then 56 for column 4. Each list runs from column 0 to column 4.
- R9: Reordering: the word at (x,y) moves to x' = (x+y) mod 4 and y' = (x'+y+1) mod 5.
- R10: Substitution: for each row x and bit z, with inputs m[k] = word (x,k) bit z, each output is o[k] = m[k] ^ (~m[k+1] & m[k+2]) ^ AND(m) ^ NOR(m), with indices taken mod 5. As a result, an all-zero state becomes all ones after one round that uses a zero constant.
- R11: The round constant is XORed into word (0,0) only, after the substitution.
- R12: While idle and not started, state_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| mode_long_i | input | 1 | 1 selects 12 rounds, 0 selects 6 rounds |
| state_i | input | 1280 | Input state, captured together with start_i |
| rc_i | input | 64 | Round constant for the round given by rnd_idx_o |
| rnd_idx_o | output | 4 | Index of the round being computed |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the run completes |
| state_o | output | 1280 | Current state; the result once done_o has pulsed |

## Verification
The checker assumes that rc_i is valid whenever busy_o is high. It does not check the constant values themselves, only that the round count and the index sequence are right. It assumes that start_i may arrive at any time, including during a run, and treats such a request as ignored rather than illegal. The bench drives rc_i combinationally from rnd_idx_o, using a constant function it owns. It raises start_i deliberately during a run, and its reference model computes the expected result from the step definitions in the requirements.

// File: rtl/sponge_perm_pkg.sv
package sponge_perm_pkg;

   localparam int GRID_ROWS = 4;
   localparam int GRID_COLS = 5;
   localparam int LANE_W    = 64;

   // doubling in GF(2^5) modulo x^5 + x^2 + 1
   function automatic logic [4:0] gf_dbl(input logic [4:0] a);
      logic [4:0] t;
      t = {a[3:0], 1'b0};
      if (a[4]) t = t ^ 5'b00101;
      return t;
   endfunction

   // multiply by 18 = 16 + 2
   function automatic logic [4:0] gf_x18(input logic [4:0] a);
      logic [4:0] a2, a4, a8, a16;
      a2  = gf_dbl(a);
      a4  = gf_dbl(a2);
      a8  = gf_dbl(a4);
      a16 = gf_dbl(a8);
      return a16 ^ a2;
   endfunction

   // rotation amount of word (row, col); the table's order is behaviour
   function automatic int lane_rot(input int row, input int col);
      case (row * 5 + col)
         0:  return 0;   1:  return 36;  2:  return 3;   3:  return 41;  4:  return 18;
         5:  return 1;   6:  return 44;  7:  return 10;  8:  return 45;  9:  return 2;
         10: return 62;  11: return 6;   12: return 43;  13: return 15;  14: return 61;
         15: return 28;  16: return 55;  17: return 25;  18: return 21;  19: return 56;
         default: return 0;
      endcase
   endfunction

   // 5-bit nonlinear substitution
   function automatic logic [4:0] sub5(input logic [4:0] m);
      logic [4:0] o;
      logic       all1, all0;
      all1 = &m;
      all0 = ~|m;
      for (int k = 0; k < 5; k++)
         o[k] = m[k] ^ (~m[(k + 1) % 5] & m[(k + 2) % 5]) ^ all1 ^ all0;
      return o;
   endfunction

endpackage

// File: rtl/sponge_col_mix.sv
module sponge_col_mix
   import sponge_perm_pkg::*;
#(
   parameter int ROWS = GRID_ROWS,
   parameter int COLS = GRID_COLS,
   parameter int W    = LANE_W,
   localparam int NW  = ROWS * COLS
) (
   input  logic [NW-1:0][W-1:0] s_i,
   output logic [NW-1:0][W-1:0] s_o
);

   for (genvar z = 0; z < W; z++) begin : g_slice
      logic [ROWS-1:0][COLS-1:0] el_in;
      logic [ROWS-1:0][COLS-1:0] el_out;

      always_comb begin
         for (int x = 0; x < ROWS; x++)
            for (int y = 0; y < COLS; y++)
               el_in[x][y] = s_i[x + ROWS * y][z];
         el_out[0] = gf_dbl(el_in[0]) ^ el_in[1]         ^ el_in[2]         ^ el_in[3];
         el_out[1] = el_in[0]         ^ el_in[1]         ^ gf_x18(el_in[2]) ^ gf_dbl(el_in[3]);
         el_out[2] = el_in[0]         ^ gf_dbl(el_in[1]) ^ el_in[2]         ^ gf_x18(el_in[3]);
         el_out[3] = el_in[0]         ^ gf_x18(el_in[1]) ^ gf_dbl(el_in[2]) ^ el_in[3];
      end

      for (genvar x = 0; x < ROWS; x++) begin : g_row
         for (genvar y = 0; y < COLS; y++) begin : g_col
            assign s_o[x + ROWS * y][z] = el_out[x][y];
         end
      end
   end

endmodule

// File: rtl/sponge_rot_move.sv
module sponge_rot_move
   import sponge_perm_pkg::*;
#(
   parameter int ROWS = GRID_ROWS,
   parameter int COLS = GRID_COLS,
   parameter int W    = LANE_W,
   localparam int NW  = ROWS * COLS
) (
   input  logic [NW-1:0][W-1:0] s_i,
   output logic [NW-1:0][W-1:0] s_o
);

   for (genvar x = 0; x < ROWS; x++) begin : g_row
      for (genvar y = 0; y < COLS; y++) begin : g_col
         localparam int AMT = lane_rot(x, y);
         localparam int NX  = (x + y) % ROWS;
         localparam int NY  = (NX + y + 1) % COLS;
         logic [W-1:0] lane;
         logic [W-1:0] rot;
         assign lane = s_i[x + ROWS * y];
         if (AMT == 0) begin : g_keep
            assign rot = lane;
         end else begin : g_rot
            assign rot = {lane[W-1-AMT:0], lane[W-1:W-AMT]};
         end
         assign s_o[NX + ROWS * NY] = rot;
      end
   end

endmodule

// File: rtl/sponge_sub_layer.sv
module sponge_sub_layer
   import sponge_perm_pkg::*;
#(
   parameter int ROWS = GRID_ROWS,
   parameter int COLS = GRID_COLS,
   parameter int W    = LANE_W,
   localparam int NW  = ROWS * COLS
) (
   input  logic [NW-1:0][W-1:0] s_i,
   output logic [NW-1:0][W-1:0] s_o
);

   for (genvar z = 0; z < W; z++) begin : g_slice
      for (genvar x = 0; x < ROWS; x++) begin : g_row
         logic [COLS-1:0] grp_in;
         logic [COLS-1:0] grp_out;
         for (genvar k = 0; k < COLS; k++) begin : g_in
            assign grp_in[k] = s_i[x + ROWS * k][z];
         end
         assign grp_out = sub5(grp_in);
         for (genvar k = 0; k < COLS; k++) begin : g_out
            assign s_o[x + ROWS * k][z] = grp_out[k];
         end
      end
   end

endmodule

// File: rtl/sponge_round_ctrl.sv
module sponge_round_ctrl #(
   parameter int SHORT_ROUNDS = 6,
   parameter int LONG_ROUNDS  = 12,
   localparam int IDX_W       = $clog2(LONG_ROUNDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             mode_long_i,
   output logic             load_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_ROUNDS - 1);
   localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(LONG_ROUNDS - 1);

   logic [IDX_W-1:0] last_q;

   assign load_o = start_i & ~busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         idx_o  <= '0;
         last_q <= '0;
      end else begin
         done_o <= 1'b0;
         if (load_o) begin
            busy_o <= 1'b1;
            idx_o  <= '0;
            last_q <= mode_long_i ? LAST_LONG : LAST_SHORT;
         end else if (busy_o) begin
            if (idx_o == last_q) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
               idx_o  <= '0;
            end else begin
               idx_o <= idx_o + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sponge_round_core.sv
module sponge_round_core
   import sponge_perm_pkg::*;
#(
   parameter int ROWS         = GRID_ROWS,
   parameter int COLS         = GRID_COLS,
   parameter int WORD_W       = LANE_W,
   parameter int SHORT_ROUNDS = 6,
   parameter int LONG_ROUNDS  = 12,
   localparam int NW          = ROWS * COLS,
   localparam int SW          = NW * WORD_W,
   localparam int IDX_W       = $clog2(LONG_ROUNDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_long_i,
   input  logic [SW-1:0]     state_i,
   input  logic [WORD_W-1:0] rc_i,
   output logic [IDX_W-1:0]  rnd_idx_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [SW-1:0]     state_o
);

   if (ROWS != 4 || COLS != 5) begin : g_bad_grid
      $error("sponge_round_core: the grid must be 4 rows by 5 columns");
   end
   if (WORD_W != 64) begin : g_bad_width
      $error("sponge_round_core: rotation table requires 64-bit words");
   end
   if (SHORT_ROUNDS < 1 || LONG_ROUNDS < SHORT_ROUNDS) begin : g_bad_rounds
      $error("sponge_round_core: round counts out of order");
   end

   logic                         load;
   logic [NW-1:0][WORD_W-1:0]    st_q;
   logic [NW-1:0][WORD_W-1:0]    after_mix;
   logic [NW-1:0][WORD_W-1:0]    after_move;
   logic [NW-1:0][WORD_W-1:0]    after_sub;
   logic [NW-1:0][WORD_W-1:0]    round_out;

   sponge_round_ctrl #(
      .SHORT_ROUNDS(SHORT_ROUNDS),
      .LONG_ROUNDS (LONG_ROUNDS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .mode_long_i(mode_long_i),
      .load_o     (load),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .idx_o      (rnd_idx_o)
   );

   sponge_col_mix #(.ROWS(ROWS), .COLS(COLS), .W(WORD_W)) u_mix (
      .s_i(st_q),
      .s_o(after_mix)
   );

   sponge_rot_move #(.ROWS(ROWS), .COLS(COLS), .W(WORD_W)) u_move (
      .s_i(after_mix),
      .s_o(after_move)
   );

   sponge_sub_layer #(.ROWS(ROWS), .COLS(COLS), .W(WORD_W)) u_sub (
      .s_i(after_move),
      .s_o(after_sub)
   );

   always_comb begin
      round_out    = after_sub;
      round_out[0] = after_sub[0] ^ rc_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else if (load) begin
         st_q <= state_i;
      end else if (busy_o) begin
         st_q <= round_out;
      end
   end

   assign state_o = st_q;

endmodule

// File: rtl/sponge_round_core_chk.sv
module sponge_round_core_chk #(
   parameter int SW           = 1280,
   parameter int SHORT_ROUNDS = 6,
   parameter int LONG_ROUNDS  = 12,
   parameter int IDX_W        = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             mode_long_i,
   input logic [SW-1:0]    state_i,
   input logic [IDX_W-1:0] rnd_idx_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [SW-1:0]    state_o
);

   int unsigned run_len_q;
   int unsigned run_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len_q <= 0;
         run_cnt_q <= 0;
      end else if (start_i && !busy_o) begin
         run_len_q <= mode_long_i ? LONG_ROUNDS : SHORT_ROUNDS;
         run_cnt_q <= 0;
      end else if (busy_o) begin
         run_cnt_q <= run_cnt_q + 1;
      end
   end

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && state_o == $past(state_i)));

   p_run_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (run_cnt_q == run_len_q));

   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (run_len_q == $past(run_len_q)));

   p_first_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (rnd_idx_o == '0));

   p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (!busy_o || rnd_idx_o == $past(rnd_idx_o) + 1'b1));

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(state_o));

endmodule

bind sponge_round_core sponge_round_core_chk #(
   .SW          (SW),
   .SHORT_ROUNDS(SHORT_ROUNDS),
   .LONG_ROUNDS (LONG_ROUNDS),
   .IDX_W       (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .mode_long_i(mode_long_i),
   .state_i    (state_i),
   .rnd_idx_o  (rnd_idx_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .state_o    (state_o)
);

// File: tb/test_sponge_round_core.sv
`timescale 1ns/1ps
module test_sponge_round_core;

   localparam int SW = 1280;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic            mode_long_i = 1'b0;
   logic [SW-1:0]   state_i = '0;
   logic [63:0]     rc_i;
   logic [3:0]      rnd_idx_o;
   logic            busy_o;
   logic            done_o;
   logic [SW-1:0]   state_o;
   bit              rc_on = 1'b0;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sponge_round_core i_sponge_round_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .mode_long_i(mode_long_i),
      .state_i    (state_i),
      .rc_i       (rc_i),
      .rnd_idx_o  (rnd_idx_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .state_o    (state_o)
   );

   function automatic logic [63:0] rc_of(input int k);
      return (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1)) ^ 64'(k);
   endfunction

   assign rc_i = rc_on ? rc_of(int'(rnd_idx_o)) : 64'h0;

   // ---------------- reference model ----------------
   int rot_tab [20] = '{0, 36, 3, 41, 18, 1, 44, 10, 45, 2,
                        62, 6, 43, 15, 61, 28, 55, 25, 21, 56};
   int mix_tab [16] = '{2, 1, 1, 1,  1, 1, 18, 2,  1, 2, 1, 18,  1, 18, 2, 1};

   function automatic logic [4:0] gmul(input logic [4:0] a, input logic [4:0] b);
      logic [4:0] acc = 5'd0;
      logic [4:0] t = a;
      for (int i = 0; i < 5; i++) begin
         if (b[i]) acc = acc ^ t;
         t = t[4] ? ({t[3:0], 1'b0} ^ 5'h05) : {t[3:0], 1'b0};
      end
      return acc;
   endfunction

   function automatic logic [SW-1:0] ref_round(input logic [SW-1:0] s, input logic [63:0] rc);
      logic [63:0] w [4][5];
      logic [63:0] v [4][5];
      logic [4:0]  e [4];
      logic [4:0]  f;
      logic [4:0]  m;
      logic [SW-1:0] r;
      for (int x = 0; x < 4; x++)
         for (int y = 0; y < 5; y++)
            w[x][y] = s[64 * (x + 4 * y) +: 64];
      // mix (R7)
      for (int z = 0; z < 64; z++) begin
         for (int x = 0; x < 4; x++)
            for (int y = 0; y < 5; y++) e[x][y] = w[x][y][z];
         for (int x = 0; x < 4; x++) begin
            f = 5'd0;
            for (int j = 0; j < 4; j++) f = f ^ gmul(5'(mix_tab[4 * x + j]), e[j]);
            for (int y = 0; y < 5; y++) v[x][y][z] = f[y];
         end
      end
      // rotate (R8) and move (R9)
      for (int x = 0; x < 4; x++)
         for (int y = 0; y < 5; y++) begin
            int nx, ny, a;
            logic [63:0] t;
            a  = rot_tab[5 * x + y];
            t  = v[x][y];
            if (a != 0) t = (t << a) | (t >> (64 - a));
            nx = (x + y) % 4;
            ny = (nx + y + 1) % 5;
            w[nx][ny] = t;
         end
      // substitution (R10)
      for (int z = 0; z < 64; z++)
         for (int x = 0; x < 4; x++) begin
            for (int k = 0; k < 5; k++) m[k] = w[x][k][z];
            for (int k = 0; k < 5; k++)
               w[x][k][z] = m[k] ^ (~m[(k + 1) % 5] & m[(k + 2) % 5]) ^ (&m) ^ (~|m);
         end
      // constant (R11)
      w[0][0] = w[0][0] ^ rc;
      for (int x = 0; x < 4; x++)
         for (int y = 0; y < 5; y++) r[64 * (x + 4 * y) +: 64] = w[x][y];
      return r;
   endfunction

   function automatic logic [SW-1:0] ref_perm(input logic [SW-1:0] s, input int n, input bit use_rc);
      logic [SW-1:0] t = s;
      for (int k = 0; k < n; k++) t = ref_round(t, use_rc ? rc_of(k) : 64'h0);
      return t;
   endfunction

   function automatic logic [SW-1:0] rand_state();
      logic [SW-1:0] t;
      for (int i = 0; i < SW / 32; i++) t[32 * i +: 32] = $urandom;
      return t;
   endfunction

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_perm(input logic [SW-1:0] st, input bit lng, input bit poke, input string req);
      logic [SW-1:0] expv;
      int n, j;
      n    = lng ? 12 : 6;
      expv = ref_perm(st, n, rc_on);
      @(negedge clk);
      state_i = st; mode_long_i = lng; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; state_i = ~st;
      j = 0;
      while (!done_o && j < 40) begin
         if (busy_o) chk(rnd_idx_o == 4'(j), "R5 index", SW'(rnd_idx_o), SW'(j));
         if (poke && j == 2) begin
            start_i = 1'b1; mode_long_i = !lng;  // R4 disturbance
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         j++;
      end
      chk(j == n, "R2 latency", SW'(j), SW'(n));
      chk(state_o == expv, req, state_o, expv);
      chk(busy_o == 1'b0, "R3 busy low at done", SW'(busy_o), SW'(0));
      @(negedge clk);
      chk(done_o == 1'b0, "R3 done width", SW'(done_o), SW'(0));
      chk(state_o == expv, "R12 result held", state_o, expv);
   endtask

   task automatic t_reset();
      chk(busy_o == 1'b0, "R1 busy", SW'(busy_o), SW'(0));
      chk(done_o == 1'b0, "R1 done", SW'(done_o), SW'(0));
      chk(rnd_idx_o == 4'd0, "R1 index", SW'(rnd_idx_o), SW'(0));
      chk(state_o == '0, "R1 state", state_o, '0);
   endtask

   task automatic t_zero_short();
      logic [SW-1:0] one_round;
      rc_on = 1'b0;
      one_round = ref_round('0, 64'h0);
      chk(one_round == {SW{1'b1}}, "R10 model all-ones", one_round, {SW{1'b1}});
      run_perm('0, 1'b0, 1'b0, "R10 zero state short");
   endtask

   task automatic t_single_bits();
      logic [SW-1:0] s;
      rc_on = 1'b0;
      s = '0; s[64 * (1 + 4 * 2) + 5] = 1'b1;      // R6 word (1,2) bit 5
      run_perm(s, 1'b0, 1'b0, "R6 R7 R8 R9 single bit");
      s = '0; s[64 * (3 + 4 * 4) + 63] = 1'b1;     // R6 top word top bit
      run_perm(s, 1'b1, 1'b0, "R6 R8 R9 corner bit");
   endtask

   task automatic t_const_long();
      rc_on = 1'b1;
      run_perm('0, 1'b1, 1'b0, "R11 constants long run");
      rc_on = 1'b0;
   endtask

   task automatic t_random();
      rc_on = 1'b1;
      for (int i = 0; i < 3; i++) run_perm(rand_state(), i[0], 1'b0, "R7 R8 R9 R10 random");
      rc_on = 1'b0;
   endtask

   task automatic t_busy_start();
      rc_on = 1'b1;
      run_perm(rand_state(), 1'b0, 1'b1, "R4 start during short run");
      run_perm(rand_state(), 1'b1, 1'b1, "R4 start during long run");
      rc_on = 1'b0;
   endtask

   task automatic t_idle_hold();
      logic [SW-1:0] held;
      held = state_o;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         state_i = rand_state(); mode_long_i = i[0];
      end
      chk(state_o == held, "R12 idle hold", state_o, held);
      chk(busy_o == 1'b0, "R12 stays idle", SW'(busy_o), SW'(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_short();
      t_single_bits();
      t_const_long();
      t_random();
      t_busy_start();
      t_idle_hold();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule